// File: doc/BRIEF.md
# Four-Lane Pixel Gather/Scatter Unit

This unit packs and unpacks pixel-style data. In gather mode it takes four 32-bit source lanes and reduces them to one word by addition, multiplication or bitwise OR. The OR mode is for packing colour channels that occupy disjoint bit ranges, where OR and addition give the same result. In scatter mode it works the other way. It cuts a 32-bit scalar into four consecutive fields of a run-time width. Each field is returned zero-extended in its own result lane, so a packed RGBA word becomes four separate channel values.

A request is offered on `start` together with its operands. It is accepted on a rising clock edge where `start` and `in_ready` are both high. This is the only back-pressure rule: a `start` seen while `in_ready` is low is dropped and leaves no trace. `in_ready` is low only while a multiply is in progress. Results are not back-pressured. `done` pulses for one cycle when a result is written, and the result lanes hold that value until the next operation completes. Add, OR and scatter complete at the accepting edge itself. Multiply runs one shared 32x32 multiplier over three further edges, in the order ((x*y)*z)*w.

Top module: `pixel_gather_scatter`

## Requirements
- R1: After reset `done` is 0, `in_ready` is 1 and all four result lanes are 0.
- R2: Opcode 2'b00 (add) writes the low 32 bits of elem0+elem1+elem2+elem3 to res0 and zeros to res1..res3. `done` is high in the cycle after the accepting edge.
- R3: Opcode 2'b10 (OR) writes elem0|elem1|elem2|elem3 to res0 and zeros to res1..res3, with the same timing as R2. When the lanes have disjoint set bits, this equals the add result.
- R4: Opcode 2'b01 (multiply) writes the low 32 bits of elem0*elem1*elem2*elem3 to res0 and zeros to res1..res3. `done` rises at the third rising edge after the accepting edge, and `in_ready` is low from the accepting edge until that edge.
- R5: With `sat_en` high, add clamps res0 to 32'hFFFFFFFF when the unsigned sum exceeds it.
- R6: With `sat_en` high, multiply clamps res0 to 32'hFFFFFFFF when the true unsigned product exceeds it. A zero in any lane still gives 0.
- R7: Opcode 2'b11 (scatter) with width w in 1..8 writes (scalar_in >> (i*w)) & (2^w-1) to res_i for i = 0..3. Source bits above bit 31 read as zero. `sat_en` has no effect, and timing is as in R2.
- R8: A `field_w` value above 8 behaves as 8. A `field_w` of 0 gives zeros in all four lanes.
- R9: A `start` while `in_ready` is low is ignored. It produces no extra `done` and does not change the running result.
- R10: `done` is high for exactly one cycle per accepted operation. The result lanes keep their value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request valid |
| in_ready | output | 1 | Unit can accept a request |
| opcode | input | 2 | 00 add, 01 multiply, 10 OR, 11 scatter |
| sat_en | input | 1 | Clamp add/multiply results to 32'hFFFFFFFF |
| field_w | input | 4 | Scatter field width |
| elem0 | input | 32 | Gather lane x |
| elem1 | input | 32 | Gather lane y |
| elem2 | input | 32 | Gather lane z |
| elem3 | input | 32 | Gather lane w |
| scalar_in | input | 32 | Scatter source word |
| res0 | output | 32 | Result lane 0 |
| res1 | output | 32 | Result lane 1 |
| res2 | output | 32 | Result lane 2 |
| res3 | output | 32 | Result lane 3 |
| done | output | 1 | One-cycle completion pulse |

## Verification
The multiply sequencer is the only multi-cycle state. A wrong step count or a lost operand shows at the ports as `done` arriving one edge early or late, or as a wrong product in res0. The check for this samples exactly three edges after acceptance. Sticky overflow or zero tracking that is not cleared between requests shows up as a wrong clamp on the very next saturating multiply. A busy flag that lets a dropped `start` through shows up as a second `done` or a corrupted product within four cycles. Scatter shift errors show up in the next result, and the lanes with high index catch field-offset mistakes.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  localparam int DATA_W   = 32;
  localparam int LANES    = 4;
  localparam int FW_W     = 4;
  localparam int MAX_FW   = 8;

  typedef enum logic [1:0] {
    OP_ADD     = 2'b00,
    OP_MUL     = 2'b01,
    OP_OR      = 2'b10,
    OP_SCATTER = 2'b11
  } pgs_op_e;

  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/pgs_reduce.sv
module pgs_reduce
  import pgs_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int N = LANES
) (
  input  logic [W-1:0] lanes [N],
  input  logic         use_or,
  input  logic         sat,
  output logic [W-1:0] result
);
  localparam int SUM_W = W + $clog2(N) + 1;

  logic [SUM_W-1:0] sum;
  logic [W-1:0]     orv;

  always_comb begin
    sum = '0;
    orv = '0;
    for (int i = 0; i < N; i++) begin
      sum = sum + SUM_W'(lanes[i]);
      orv = orv | lanes[i];
    end
  end

  always_comb begin
    if (use_or)
      result = orv;
    else if (sat && (sum[SUM_W-1:W] != '0))
      result = '1;
    else
      result = sum[W-1:0];
  end
endmodule

// File: rtl/pgs_split.sv
module pgs_split
  import pgs_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int N     = LANES,
  parameter int FWW   = FW_W,
  parameter int FWMAX = MAX_FW
) (
  input  logic [W-1:0]   src,
  input  logic [FWW-1:0] width_eff,
  output logic [W-1:0]   fields [N]
);
  localparam int SH_W = $clog2(N * FWMAX + 1) + 1;

  logic [W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int b = 0; b < FWMAX; b++)
      if (b < int'(width_eff)) mask[b] = 1'b1;
  end

  for (genvar g = 0; g < N; g++) begin : g_field
    logic [SH_W-1:0] sh;
    always_comb begin
      sh = SH_W'(g) * SH_W'(width_eff);
      fields[g] = (src >> sh) & mask;
    end
  end

  always_comb begin
    if (width_eff == '0)
      assert_zero_width_R8: assert (fields[N-1] == '0);
  end
endmodule

// File: rtl/pgs_mulseq.sv
module pgs_mulseq
  import pgs_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int N = LANES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] lanes [N],
  output logic         busy,
  output logic         last,
  output logic [W-1:0] next_low,
  output logic         next_ovf,
  output logic         next_zero
);
  localparam int STEPS  = N - 1;
  localparam int STEP_W = $clog2(STEPS + 1);

  logic [W-1:0]      acc;
  logic [W-1:0]      pend [STEPS];
  logic [STEP_W-1:0] step;
  logic              ovf_q, zero_q;
  logic [2*W-1:0]    prod;
  logic [W-1:0]      opnd;

  assign opnd      = pend[step];
  assign prod      = {{W{1'b0}}, acc} * {{W{1'b0}}, opnd};
  assign last      = busy && (step == STEP_W'(STEPS - 1));
  assign next_low  = prod[W-1:0];
  assign next_ovf  = ovf_q | (prod[2*W-1:W] != '0);
  assign next_zero = zero_q | (opnd == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      step   <= '0;
      busy   <= 1'b0;
      ovf_q  <= 1'b0;
      zero_q <= 1'b0;
      for (int i = 0; i < STEPS; i++) pend[i] <= '0;
    end else if (load) begin
      acc    <= lanes[0];
      step   <= '0;
      busy   <= 1'b1;
      ovf_q  <= 1'b0;
      zero_q <= (lanes[0] == '0);
      for (int i = 0; i < STEPS; i++) pend[i] <= lanes[i+1];
    end else if (busy) begin
      acc    <= next_low;
      ovf_q  <= next_ovf;
      zero_q <= next_zero;
      step   <= step + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  assert_load_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && step == '0));
  assert_steps_continue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
  assert_last_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !load) |=> !busy);
endmodule

// File: rtl/pixel_gather_scatter.sv
module pixel_gather_scatter
  import pgs_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int FWW   = FW_W,
  parameter int FWMAX = MAX_FW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           in_ready,
  input  logic [1:0]     opcode,
  input  logic           sat_en,
  input  logic [FWW-1:0] field_w,
  input  logic [W-1:0]   elem0,
  input  logic [W-1:0]   elem1,
  input  logic [W-1:0]   elem2,
  input  logic [W-1:0]   elem3,
  input  logic [W-1:0]   scalar_in,
  output logic [W-1:0]   res0,
  output logic [W-1:0]   res1,
  output logic [W-1:0]   res2,
  output logic [W-1:0]   res3,
  output logic           done
);
  localparam int N = LANES;

  logic [W-1:0]   lanes  [N];
  logic [W-1:0]   fields [N];
  logic [W-1:0]   res_q  [N];
  logic [W-1:0]   red_out;
  logic [FWW-1:0] w_eff;
  logic [FWW-1:0] w_q;
  pgs_op_e        op_in, op_q;
  logic           accept, mul_busy, mul_last, m_ovf, m_zero, sat_q;
  logic [W-1:0]   m_low;

  assign lanes[0] = elem0;
  assign lanes[1] = elem1;
  assign lanes[2] = elem2;
  assign lanes[3] = elem3;
  assign op_in    = pgs_op_e'(opcode);
  assign in_ready = !mul_busy;
  assign accept   = start && in_ready;
  assign w_eff    = (field_w > FWW'(FWMAX)) ? FWW'(FWMAX) : field_w;

  pgs_reduce #(.W(W), .N(N)) u_reduce (
    .lanes  (lanes),
    .use_or (op_in == OP_OR),
    .sat    (sat_en),
    .result (red_out)
  );

  pgs_split #(.W(W), .N(N), .FWW(FWW), .FWMAX(FWMAX)) u_split (
    .src       (scalar_in),
    .width_eff (w_eff),
    .fields    (fields)
  );

  pgs_mulseq #(.W(W), .N(N)) u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && op_in == OP_MUL),
    .lanes     (lanes),
    .busy      (mul_busy),
    .last      (mul_last),
    .next_low  (m_low),
    .next_ovf  (m_ovf),
    .next_zero (m_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      op_q  <= OP_ADD;
      w_q   <= '0;
      sat_q <= 1'b0;
      for (int i = 0; i < N; i++) res_q[i] <= '0;
    end else begin
      done <= 1'b0;
      if (mul_last) begin
        done     <= 1'b1;
        res_q[0] <= (sat_q && !m_zero && m_ovf) ? '1 : m_low;
        for (int i = 1; i < N; i++) res_q[i] <= '0;
      end else if (accept) begin
        op_q  <= op_in;
        w_q   <= w_eff;
        sat_q <= sat_en;
        if (op_in == OP_SCATTER) begin
          done <= 1'b1;
          for (int i = 0; i < N; i++) res_q[i] <= fields[i];
        end else if (op_in != OP_MUL) begin
          done     <= 1'b1;
          res_q[0] <= red_out;
          for (int i = 1; i < N; i++) res_q[i] <= '0;
        end
      end
    end
  end

  assign res0 = res_q[0];
  assign res1 = res_q[1];
  assign res2 = res_q[2];
  assign res3 = res_q[3];

  assert_mul_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mul_last |=> done);
  assert_busy_start_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_ready && !mul_last) |=> !done);
  assert_gather_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q != OP_SCATTER) |-> (res1 == '0 && res2 == '0 && res3 == '0));
  assert_field_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_SCATTER) |->
      ((res0 >> w_q) == '0 && (res1 >> w_q) == '0 &&
       (res2 >> w_q) == '0 && (res3 >> w_q) == '0));
  assert_hold_results_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !mul_last) |=> ($stable(res0) && $stable(res3) && !done));
endmodule

// File: tb/test_pixel_gather_scatter.sv
module test_pixel_gather_scatter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        in_ready;
  logic [1:0]  opcode;
  logic        sat_en;
  logic [3:0]  field_w;
  logic [31:0] elem0, elem1, elem2, elem3, scalar_in;
  logic [31:0] res0, res1, res2, res3;
  logic        done;

  int vectors = 0;
  int bad     = 0;
  int lat;

  always #10 clk = ~clk;

  pixel_gather_scatter i_pixel_gather_scatter (
    .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
    .opcode(opcode), .sat_en(sat_en), .field_w(field_w),
    .elem0(elem0), .elem1(elem1), .elem2(elem2), .elem3(elem3),
    .scalar_in(scalar_in), .res0(res0), .res1(res1), .res2(res2),
    .res3(res3), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic s, input logic [3:0] w,
                       input logic [31:0] a, b, c, d, sc);
    @(negedge clk);
    opcode = op; sat_en = s; field_w = w;
    elem0 = a; elem1 = b; elem2 = c; elem3 = d; scalar_in = sc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    for (int k = 0; k < 20 && !done; k++) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_gather(input string req, input logic [31:0] exp, input int exp_lat);
    chk(req, res0, exp);
    chk(req, res1 | res2 | res3, 32'h0);
    chk(req, 32'(lat), 32'(exp_lat));
    @(negedge clk);
    chk({req, " R10 pulse"}, {31'b0, done}, 32'h0);
    chk({req, " R10 hold"}, res0, exp);
  endtask

  function automatic logic [31:0] ref_prod(input logic [31:0] a, b, c, d, input logic s);
    logic [127:0] p;
    p = 128'(a) * 128'(b) * 128'(c) * 128'(d);
    if (s && p > 128'hFFFF_FFFF) return 32'hFFFF_FFFF;
    return p[31:0];
  endfunction

  function automatic logic [31:0] ref_field(input logic [31:0] src, input int w, input int i);
    logic [63:0] t;
    t = (64'(src) >> (i * w)) & ((64'd1 << w) - 1);
    return t[31:0];
  endfunction

  task automatic t_reset();
    chk("R1 done", {31'b0, done}, 32'h0);
    chk("R1 ready", {31'b0, in_ready}, 32'h1);
    chk("R1 res", res0 | res1 | res2 | res3, 32'h0);
  endtask

  task automatic t_add();
    issue(2'b00, 1'b0, 4'd0, 32'd10, 32'd20, 32'd30, 32'd40, 32'h0);
    check_gather("R2 small", 32'd100, 1);
    issue(2'b00, 1'b0, 4'd0, 32'hFFFF_FFFF, 32'd2, 32'd3, 32'd4, 32'h0);
    check_gather("R2 wrap", 32'd8, 1);
  endtask

  task automatic t_or();
    issue(2'b10, 1'b0, 4'd0, 32'h0000_00AA, 32'h0000_BB00, 32'h00CC_0000, 32'hDD00_0000, 32'h0);
    check_gather("R3 pack", 32'hDDCC_BBAA, 1);
    issue(2'b10, 1'b0, 4'd0, 32'h0F0F_0001, 32'h00FF_0003, 32'h0, 32'h8000_0000, 32'h0);
    check_gather("R3 overlap", 32'h8FFF_0003, 1);
  endtask

  task automatic t_mul();
    issue(2'b01, 1'b0, 4'd0, 32'd3, 32'd5, 32'd7, 32'd11, 32'h0);
    check_gather("R4 small", 32'd1155, 4);
    issue(2'b01, 1'b0, 4'd0, 32'h0001_0001, 32'h0001_0003, 32'd17, 32'hFFFF_FFF1, 32'h0);
    check_gather("R4 wrap", ref_prod(32'h0001_0001, 32'h0001_0003, 32'd17, 32'hFFFF_FFF1, 1'b0), 4);
  endtask

  task automatic t_sat();
    issue(2'b00, 1'b1, 4'd0, 32'hFFFF_FFF0, 32'd8, 32'd8, 32'd0, 32'h0);
    check_gather("R5 clamp", 32'hFFFF_FFFF, 1);
    issue(2'b00, 1'b1, 4'd0, 32'hFFFF_FFF0, 32'd8, 32'd7, 32'd0, 32'h0);
    check_gather("R5 fits", 32'hFFFF_FFFF, 1);
    issue(2'b00, 1'b1, 4'd0, 32'h1000, 32'h20, 32'h3, 32'h0, 32'h0);
    check_gather("R5 small", 32'h1023, 1);
    issue(2'b01, 1'b1, 4'd0, 32'h0001_0000, 32'h0001_0000, 32'd2, 32'd3, 32'h0);
    check_gather("R6 clamp", 32'hFFFF_FFFF, 4);
    issue(2'b01, 1'b1, 4'd0, 32'h0001_0000, 32'h0001_0000, 32'd2, 32'd0, 32'h0);
    check_gather("R6 zero lane", 32'h0, 4);
    issue(2'b01, 1'b1, 4'd0, 32'd1000, 32'd1000, 32'd1000, 32'd4, 32'h0);
    check_gather("R6 fits", ref_prod(32'd1000, 32'd1000, 32'd1000, 32'd4, 1'b1), 4);
  endtask

  task automatic t_scatter(input int w, input int wexp, input logic [31:0] src, input string req);
    issue(2'b11, 1'b1, 4'(w), 32'hFFFF_FFFF, 32'h1, 32'h1, 32'h1, src);
    chk({req, " lane0"}, res0, ref_field(src, wexp, 0));
    chk({req, " lane1"}, res1, ref_field(src, wexp, 1));
    chk({req, " lane2"}, res2, ref_field(src, wexp, 2));
    chk({req, " lane3"}, res3, ref_field(src, wexp, 3));
    chk({req, " latency"}, 32'(lat), 32'd1);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    opcode = 2'b01; sat_en = 1'b0;
    elem0 = 32'd2; elem1 = 32'd3; elem2 = 32'd4; elem3 = 32'd5;
    start = 1'b1;
    @(negedge clk);
    chk("R4 ready low", {31'b0, in_ready}, 32'h0);
    opcode = 2'b00; elem0 = 32'd100;
    @(negedge clk);
    chk("R9 no early done", {31'b0, done}, 32'h0);
    opcode = 2'b10;
    @(negedge clk);
    start = 1'b0;
    chk("R9 still busy", {31'b0, done}, 32'h0);
    @(negedge clk);
    chk("R9 done on time", {31'b0, done}, 32'h1);
    chk("R9 product intact", res0, 32'd120);
    chk("R4 ready back", {31'b0, in_ready}, 32'h1);
    @(negedge clk);
    chk("R9 no second done", {31'b0, done}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; opcode = 2'b00; sat_en = 1'b0; field_w = 4'd0;
    elem0 = '0; elem1 = '0; elem2 = '0; elem3 = '0; scalar_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_add();
    t_or();
    t_mul();
    t_sat();
    t_scatter(8, 8, 32'h11AA_55FF, "R7 rgba");
    t_scatter(5, 5, 32'hDEAD_BEEF, "R7 w5");
    t_scatter(1, 1, 32'h0000_000A, "R7 w1");
    t_scatter(8, 8, 32'h8000_0001, "R7 top bit");
    t_scatter(13, 8, 32'hCAFE_F00D, "R8 wide");
    t_scatter(0, 0, 32'hFFFF_FFFF, "R8 zero");
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule